// File: doc/BRIEF.md
# Scan-Synchronised Condition Marker Exchange

This block passes single-bit condition markers between two processors that run their scans independently and never wait for each other. Each side owns a private set of markers, one per index, and sets or clears any of them through an addressed bit write port whenever its program produces a new result. The other side never reads these live markers directly. It keeps a private image of them and refreshes that image only when it pulses its update strobe, which it does at the end of its scan together with its process input refresh.

The whole set of markers is copied in a single clock cycle. The reader's view therefore behaves like a process input image: it stays constant for a whole scan, whatever the writer does meanwhile. A marker that is raised and dropped again between two refreshes is not seen by the reader. The block holds two mirrored directions. Side A writes markers that side B reads, and side B writes markers that side A reads. Each writer has its own region, so no storage cell has two writers.

Top module: `cond_xchg`

## Requirements
- R1: After reset, every marker in both live sets and both images reads 0, and a refresh with no preceding write still yields all 0.
- R2: A write with enable high sets the marker at the 5-bit index to the written value at the next clock edge and leaves every other marker of that set unchanged.
- R3: A write has no effect on the reader's image until the reader pulses its update strobe.
- R4: One update strobe copies all 32 live markers of the other side into the reader's image at the next clock edge.
- R5: Between two update strobes the reader's image does not change, whatever the writer does.
- R6: When a write and the reader's update fall in the same cycle, the image takes the marker value from before the write, and the written value appears after the next update.
- R7: A marker set and cleared again between two updates is read as 0 after the second update.
- R8: The two directions are independent: writes by A appear only in B's image, writes by B only in A's image, and each side's strobe refreshes only its own image.
- R9: The read port returns the image marker whose number equals the 5-bit read index, index 0 selecting marker 0 and index 31 marker 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_wr_en | input | 1 | Side A marker write enable |
| a_wr_idx | input | 5 | Side A marker number to write |
| a_wr_val | input | 1 | Value written to side A's marker |
| a_upd | input | 1 | Side A end-of-scan strobe: refresh A's image of B's markers |
| a_rd_idx | input | 5 | Marker number side A reads from its image |
| a_rd_val | output | 1 | Selected marker of A's image of B's markers |
| b_wr_en | input | 1 | Side B marker write enable |
| b_wr_idx | input | 5 | Side B marker number to write |
| b_wr_val | input | 1 | Value written to side B's marker |
| b_upd | input | 1 | Side B end-of-scan strobe: refresh B's image of A's markers |
| b_rd_idx | input | 5 | Marker number side B reads from its image |
| b_rd_val | output | 1 | Selected marker of B's image of A's markers |

## Verification
The writer's bit write and the reader's image refresh can land on the same clock edge, since the two sides run without any handshake. The bench drives a write of a fresh value and the reader's strobe on the same cycle, then reads the image over the read port and expects the old marker value, and after a second strobe expects the new one. A clocked property compares the image after each strobe with the live set as it stood in the strobe cycle, so any refresh that leaks the same-cycle write is flagged.

// File: rtl/cond_xchg_pkg.sv
package cond_xchg_pkg;

  localparam int unsigned COND_NUM_DEFAULT = 32;
  localparam int unsigned RST_STAGES_DEFAULT = 2;

  function automatic int unsigned idx_width(input int unsigned n);
    if (n <= 1) return 1;
    return $clog2(n);
  endfunction

endpackage

// File: rtl/cond_rst_sync.sv
module cond_rst_sync #(
  parameter int unsigned STAGES = cond_xchg_pkg::RST_STAGES_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/cond_live_reg.sv
module cond_live_reg #(
  parameter int unsigned NUM = cond_xchg_pkg::COND_NUM_DEFAULT,
  localparam int unsigned IW = cond_xchg_pkg::idx_width(NUM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_val,
  output logic [NUM-1:0] live_q
);

  logic [NUM-1:0] hit;
  logic [NUM-1:0] live_d;
  logic           live_ce;

  for (genvar i = 0; i < NUM; i++) begin : g_bit
    always_comb begin
      hit[i]    = wr_en && (wr_idx == IW'(i));
      live_d[i] = hit[i] ? wr_val : live_q[i];
    end
  end

  assign live_ce = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       live_q <= '0;
    else if (live_ce) live_q <= live_d;
  end

endmodule

// File: rtl/cond_snap_reg.sv
module cond_snap_reg #(
  parameter int unsigned NUM = cond_xchg_pkg::COND_NUM_DEFAULT,
  localparam int unsigned IW = cond_xchg_pkg::idx_width(NUM)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd,
  input  logic [NUM-1:0] live_i,
  input  logic [IW-1:0]  rd_idx,
  output logic           rd_val,
  output logic [NUM-1:0] img_q
);

  logic [NUM-1:0] img_d;

  always_comb begin
    img_d = live_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   img_q <= '0;
    else if (upd) img_q <= img_d;
  end

  always_comb begin
    rd_val = 1'b0;
    for (int i = 0; i < NUM; i++) begin
      if (rd_idx == IW'(i)) rd_val = img_q[i];
    end
  end

endmodule

// File: rtl/cond_lane.sv
module cond_lane #(
  parameter int unsigned NUM = cond_xchg_pkg::COND_NUM_DEFAULT,
  localparam int unsigned IW = cond_xchg_pkg::idx_width(NUM)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic           wr_val,
  input  logic           upd,
  input  logic [IW-1:0]  rd_idx,
  output logic           rd_val,
  output logic [NUM-1:0] live_o,
  output logic [NUM-1:0] img_o
);

  cond_live_reg #(.NUM(NUM)) u_live (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_val (wr_val),
    .live_q (live_o)
  );

  cond_snap_reg #(.NUM(NUM)) u_snap (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (upd),
    .live_i (live_o),
    .rd_idx (rd_idx),
    .rd_val (rd_val),
    .img_q  (img_o)
  );

endmodule

// File: rtl/cond_xchg.sv
module cond_xchg #(
  parameter int unsigned NUM = cond_xchg_pkg::COND_NUM_DEFAULT,
  parameter int unsigned RST_STAGES = cond_xchg_pkg::RST_STAGES_DEFAULT,
  localparam int unsigned IW = cond_xchg_pkg::idx_width(NUM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_wr_en,
  input  logic [IW-1:0] a_wr_idx,
  input  logic          a_wr_val,
  input  logic          a_upd,
  input  logic [IW-1:0] a_rd_idx,
  output logic          a_rd_val,
  input  logic          b_wr_en,
  input  logic [IW-1:0] b_wr_idx,
  input  logic          b_wr_val,
  input  logic          b_upd,
  input  logic [IW-1:0] b_rd_idx,
  output logic          b_rd_val
);

  logic           rst_core_n;
  logic [NUM-1:0] ab_live;
  logic [NUM-1:0] ab_img;
  logic [NUM-1:0] ba_live;
  logic [NUM-1:0] ba_img;

  cond_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  // A writes, B refreshes and reads
  cond_lane #(.NUM(NUM)) u_a2b (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_en  (a_wr_en),
    .wr_idx (a_wr_idx),
    .wr_val (a_wr_val),
    .upd    (b_upd),
    .rd_idx (b_rd_idx),
    .rd_val (b_rd_val),
    .live_o (ab_live),
    .img_o  (ab_img)
  );

  // B writes, A refreshes and reads
  cond_lane #(.NUM(NUM)) u_b2a (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_en  (b_wr_en),
    .wr_idx (b_wr_idx),
    .wr_val (b_wr_val),
    .upd    (a_upd),
    .rd_idx (a_rd_idx),
    .rd_val (a_rd_val),
    .live_o (ba_live),
    .img_o  (ba_img)
  );

endmodule

// File: rtl/cond_xchg_chk.sv
module cond_xchg_chk #(
  parameter int unsigned NUM = 32,
  parameter int unsigned IW = 5
) (
  input logic           clk,
  input logic           rst_core_n,
  input logic           a_wr_en,
  input logic [IW-1:0]  a_wr_idx,
  input logic           a_wr_val,
  input logic           a_upd,
  input logic           b_upd,
  input logic [NUM-1:0] ab_live,
  input logic [NUM-1:0] ab_img,
  input logic [NUM-1:0] ba_live,
  input logic [NUM-1:0] ba_img
);

  // R1: reset holds all state at zero
  p_rst_clear_r1: assert property (@(posedge clk)
    !rst_core_n |-> (ab_live == '0 && ab_img == '0 && ba_live == '0 && ba_img == '0));

  // R2: addressed write lands on the chosen marker
  p_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    a_wr_en |=> ab_live[$past(a_wr_idx)] == $past(a_wr_val));

  // R2: at most one marker of a set changes per cycle
  p_wr_onebit_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    $countones(ab_live ^ $past(ab_live)) <= 1);

  // R2: no write, no change of the live set
  p_wr_idle_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    !a_wr_en |=> $stable(ab_live));

  // R4 / R6: a refresh takes the live set as it was in the strobe cycle
  p_img_copy_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    b_upd |=> ab_img == $past(ab_live));

  // R5: image frozen without a strobe
  p_img_hold_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    !b_upd |=> $stable(ab_img));

  // R8: the other direction follows only its own strobe
  p_other_hold_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    !a_upd |=> $stable(ba_img));

endmodule

bind cond_xchg cond_xchg_chk #(.NUM(NUM), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .a_wr_en    (a_wr_en),
  .a_wr_idx   (a_wr_idx),
  .a_wr_val   (a_wr_val),
  .a_upd      (a_upd),
  .b_upd      (b_upd),
  .ab_live    (ab_live),
  .ab_img     (ab_img),
  .ba_live    (ba_live),
  .ba_img     (ba_img)
);

// File: tb/cond_xchg_bench.sv
`timescale 1ns/1ps
module cond_xchg_bench;

  logic       clk;
  logic       rst_n;
  logic       a_wr_en, a_wr_val, a_upd, b_wr_en, b_wr_val, b_upd;
  logic [4:0] a_wr_idx, a_rd_idx, b_wr_idx, b_rd_idx;
  logic       a_rd_val, b_rd_val;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model: live sets and images derived from the requirements
  logic [31:0] m_ab_live, m_ab_img, m_ba_live, m_ba_img;

  cond_xchg u_cond_xchg (
    .clk(clk), .rst_n(rst_n),
    .a_wr_en(a_wr_en), .a_wr_idx(a_wr_idx), .a_wr_val(a_wr_val),
    .a_upd(a_upd), .a_rd_idx(a_rd_idx), .a_rd_val(a_rd_val),
    .b_wr_en(b_wr_en), .b_wr_idx(b_wr_idx), .b_wr_val(b_wr_val),
    .b_upd(b_upd), .b_rd_idx(b_rd_idx), .b_rd_val(b_rd_val)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // read a whole image through the read port, inside the low clock phase
  task automatic read_img(input bit side_b, output logic [31:0] v);
    for (int i = 0; i < 32; i++) begin
      if (side_b) b_rd_idx = 5'(i); else a_rd_idx = 5'(i);
      #0.1;
      v[i] = side_b ? b_rd_val : a_rd_val;
    end
  endtask

  // one cycle of stimulus, applied at a falling edge, removed at the next
  task automatic step(input bit aw, input int ai, input bit av, input bit au,
                      input bit bw, input int bi, input bit bv, input bit bu);
    @(negedge clk);
    a_wr_en = aw; a_wr_idx = 5'(ai); a_wr_val = av; a_upd = au;
    b_wr_en = bw; b_wr_idx = 5'(bi); b_wr_val = bv; b_upd = bu;
    if (au) m_ba_img = m_ba_live;
    if (bu) m_ab_img = m_ab_live;
    if (aw) m_ab_live[ai] = av;
    if (bw) m_ba_live[bi] = bv;
    @(negedge clk);
    a_wr_en = 0; a_upd = 0; b_wr_en = 0; b_upd = 0;
  endtask

  task automatic wr_a(input int i, input bit v); step(1, i, v, 0, 0, 0, 0, 0); endtask
  task automatic wr_b(input int i, input bit v); step(0, 0, 0, 0, 1, i, v, 0); endtask
  task automatic upd_a(); step(0, 0, 0, 1, 0, 0, 0, 0); endtask
  task automatic upd_b(); step(0, 0, 0, 0, 0, 0, 0, 1); endtask

  task automatic t_reset();
    logic [31:0] v;
    read_img(1, v); check("R1 b image after reset", v, 32'h0);
    read_img(0, v); check("R1 a image after reset", v, 32'h0);
    upd_a(); upd_b();
    read_img(1, v); check("R1 b refresh of cleared live", v, 32'h0);
    read_img(0, v); check("R1 a refresh of cleared live", v, 32'h0);
  endtask

  task automatic t_bitwrite();
    logic [31:0] v;
    wr_a(0, 1); wr_a(31, 1); wr_a(5, 1);
    read_img(1, v); check("R3 image untouched before strobe", v, 32'h0);
    upd_b();
    read_img(1, v); check("R2 R4 three markers set", v, m_ab_img);
    check("R2 expected pattern", m_ab_img, 32'h8000_0021);
    wr_a(5, 0); upd_b();
    read_img(1, v); check("R2 clear one marker only", v, 32'h8000_0001);
  endtask

  task automatic t_hold();
    logic [31:0] v, a0;
    read_img(0, a0);
    for (int i = 8; i < 16; i++) wr_a(i, 1);
    read_img(1, v); check("R5 image frozen during writes", v, 32'h8000_0001);
    read_img(0, v); check("R8 a image unaffected by a writes", v, a0);
    upd_b();
    read_img(1, v); check("R4 full copy after strobe", v, 32'h8000_ff01);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    step(1, 7, 1, 0, 0, 0, 0, 1);
    read_img(1, v); check("R6 same-cycle write not captured", v[7], 1'b0);
    check("R6 rest of image", v, 32'h8000_ff01);
    upd_b();
    read_img(1, v); check("R6 write seen on next strobe", v[7], 1'b1);
    step(1, 0, 0, 0, 0, 0, 0, 1);
    read_img(1, v); check("R6 same-cycle clear keeps old 1", v[0], 1'b1);
  endtask

  task automatic t_glitch();
    logic [31:0] v;
    upd_b();
    wr_a(20, 1); wr_a(20, 0);
    upd_b();
    read_img(1, v); check("R7 short pulse not seen", v[20], 1'b0);
    check("R7 image matches model", v, m_ab_img);
  endtask

  task automatic t_reverse();
    logic [31:0] v, b0;
    read_img(1, b0);
    wr_b(3, 1); wr_b(30, 1);
    read_img(0, v); check("R8 a image before a strobe", v, 32'h0);
    upd_b();
    read_img(1, v); check("R8 b strobe ignores b writes", v, b0);
    upd_a();
    read_img(0, v); check("R8 a sees b markers", v, 32'h4000_0008);
    // simultaneous refresh on both sides
    wr_a(1, 1); wr_b(2, 1);
    step(0, 0, 0, 1, 0, 0, 0, 1);
    read_img(0, v); check("R8 a image both strobes", v, m_ba_img);
    read_img(1, v); check("R8 b image both strobes", v, m_ab_img);
  endtask

  task automatic t_walk();
    logic [31:0] v;
    for (int i = 0; i < 32; i++) wr_a(i, 0);
    for (int i = 0; i < 32; i++) begin
      wr_a(i, 1);
      if (i > 0) wr_a(i - 1, 0);
      upd_b();
      read_img(1, v);
      check($sformatf("R9 walking marker %0d", i), v, 32'h1 << i);
    end
  endtask

  initial begin
    rst_n = 0;
    a_wr_en = 0; a_wr_idx = 0; a_wr_val = 0; a_upd = 0; a_rd_idx = 0;
    b_wr_en = 0; b_wr_idx = 0; b_wr_val = 0; b_upd = 0; b_rd_idx = 0;
    m_ab_live = 0; m_ab_img = 0; m_ba_live = 0; m_ba_img = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bitwrite();
    t_hold();
    t_collide();
    t_glitch();
    t_reverse();
    t_walk();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule